// File: doc/BRIEF.md
# Peak Current-Mode Switch Gate Controller

This block drives the power-switch gate of a fixed-frequency, peak current-mode converter. A digital ramp oscillator climbs slowly and falls quickly. The switch closes on the clock edge where a climb begins. It opens on the first edge that samples the synchronous "sensed current above command" comparator input. After that it stays open until the next climb begins, so the regulation loop acts one cycle at a time. The switch is held open for the whole fall of the ramp. The ratio of the climb and fall step sizes therefore sets the largest duty cycle, with no separate blanking counter.

Two shutdown inputs pass through a short synchronizer: a high-active halt pin and an overvoltage flag. Each forces the gate off and drops any on-state in progress. The switch may close again only at a fresh climb. A switch current-limit flag masks the gate output combinationally and ends the on-time at once. A feedback-select pin steers a one-hot channel output for the external two-input feedback multiplexer.

Top module: `pcm_gate_ctrl`

## Requirements
- R1: `gate_o` rises only in the first cycle of a charge phase. It does so only when trip, current limit and the synchronized shutdown were all low at the edge that began that phase.
- R2: If `trip_i` is high while `gate_o` is high, `gate_o` is low after the next rising clock edge.
- R3: `charge_o` is high for ceil((TOP-BOT)/UP) cycles, then low for ceil((TOP-BOT)/DN) cycles. With the defaults this is 40 high and 5 low, a 45-cycle period. `gate_o` is never high while `charge_o` is low.
- R4: `halt_i` sampled high at an edge forces `gate_o` low from the second edge after it onwards, with one synchronizer stage by default. It does so regardless of the other inputs.
- R5: `ovp_i` sampled high has the same effect and the same timing as `halt_i`.
- R6: Once `gate_o` is low during a charge phase, for any reason, it stays low until the next charge phase begins. This holds even after a shutdown input is released.
- R7: While `ilim_i` is high, `gate_o` is low in that same cycle. The on-time also ends for the rest of the period.
- R8: A trip already sampled high at the edge that begins a charge phase keeps `gate_o` low for that entire period, even if the trip falls during the phase.
- R9: `fb_chan_o` is one-hot and is updated one edge after `fb_sel_i` is sampled. Value 2'b01 (bit 0) selects feedback channel 1 when the select input is low. Value 2'b10 (bit 1) selects channel 2 when it is high. The reset value is 2'b10.
- R10: In reset, `gate_o`=0, `charge_o`=0 and `ramp_o`=BOT. The first edge after reset begins a charge phase. `ramp_o` climbs by UP per cycle from BOT, clamps at TOP and falls by DN per cycle. It stays within [BOT, TOP]; with the defaults it falls 40,32,24,16,8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | High shuts the switch off |
| ovp_i | input | 1 | Overvoltage flag, high shuts the switch off |
| fb_sel_i | input | 1 | Feedback select: 0 selects channel 1, 1 selects channel 2 |
| trip_i | input | 1 | Synchronous comparator: sensed current above command |
| ilim_i | input | 1 | Switch current-limit flag |
| gate_o | output | 1 | Power-switch gate |
| charge_o | output | 1 | High during the ramp climb phase |
| ramp_o | output | RAMP_W | Ramp oscillator value |
| fb_chan_o | output | 2 | One-hot selected feedback channel |

## Verification
Free-running periods with no trips show that the gate follows the climb phase exactly, which pins down the duty limit. A single-cycle trip mid-climb separates cycle-by-cycle termination from a latch that reopens. A trip held across the start of a climb separates runt-pulse suppression from plain edge-triggered turn-on. Shutdown pulses released mid-climb, including an overvoltage spanning a phase start, show that the gate resumes only at a fresh climb. A one-cycle current-limit pulse separates the combinational mask from the registered trip path. Select toggles check the one-hot encoding and its one-edge latency.

// File: rtl/pcm_gate_pkg.sv
package pcm_gate_pkg;

   typedef enum logic {
      PH_FALL  = 1'b0,
      PH_CLIMB = 1'b1
   } ramp_phase_e;

   localparam logic [1:0] FB_CH1 = 2'b01;
   localparam logic [1:0] FB_CH2 = 2'b10;

   function automatic int unsigned ceil_steps(input int unsigned span, input int unsigned step);
      return (span + step - 1) / step;
   endfunction

endpackage

// File: rtl/pcm_ramp_osc.sv
module pcm_ramp_osc
   import pcm_gate_pkg::*;
#(
   parameter int RAMP_W = 8,
   parameter int TOP    = 40,
   parameter int BOT    = 0,
   parameter int UP     = 1,
   parameter int DN     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [RAMP_W-1:0] ramp_o,
   output ramp_phase_e       phase_o,
   output logic              start_o,
   output logic              end_o
);

   localparam int XW = RAMP_W + 1;
   localparam logic [XW-1:0] TOP_X  = XW'(TOP);
   localparam logic [XW-1:0] BOT_X  = XW'(BOT);
   localparam logic [XW-1:0] UP_X   = XW'(UP);
   localparam logic [XW-1:0] DN_X   = XW'(DN);
   localparam logic [XW-1:0] WRAP_X = XW'(BOT + DN);

   logic [RAMP_W-1:0] cnt_q, cnt_d;
   ramp_phase_e       ph_q, ph_d;
   logic [XW-1:0]     cnt_x, up_sum, dn_dif;

   always_comb begin
      cnt_x   = {1'b0, cnt_q};
      up_sum  = cnt_x + UP_X;
      dn_dif  = cnt_x - DN_X;
      start_o = (ph_q == PH_FALL)  && (cnt_x <= WRAP_X);
      end_o   = (ph_q == PH_CLIMB) && (up_sum >= TOP_X);
      cnt_d   = cnt_q;
      ph_d    = ph_q;
      if (ph_q == PH_CLIMB) begin
         if (end_o) begin
            cnt_d = TOP_X[RAMP_W-1:0];
            ph_d  = PH_FALL;
         end else begin
            cnt_d = up_sum[RAMP_W-1:0];
         end
      end else begin
         if (start_o) begin
            cnt_d = BOT_X[RAMP_W-1:0];
            ph_d  = PH_CLIMB;
         end else begin
            cnt_d = dn_dif[RAMP_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= BOT_X[RAMP_W-1:0];
         ph_q  <= PH_FALL;
      end else begin
         cnt_q <= cnt_d;
         ph_q  <= ph_d;
      end
   end

   assign ramp_o  = cnt_q;
   assign phase_o = ph_q;

endmodule

// File: rtl/pcm_sd_sync.sv
module pcm_sd_sync #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_i,
   input  logic ovp_i,
   output logic sd_o
);

   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= halt_i | ovp_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], halt_i | ovp_i};
         end
      end
   endgenerate

   assign sd_o = sh_q[STAGES-1];

endmodule

// File: rtl/pcm_gate_latch.sv
module pcm_gate_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic end_i,
   input  logic trip_i,
   input  logic ilim_i,
   input  logic sd_i,
   output logic gate_o
);

   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (sd_i) begin
         gate_q <= 1'b0;
      end else if (start_i) begin
         gate_q <= !trip_i && !ilim_i;
      end else if (end_i || trip_i || ilim_i) begin
         gate_q <= 1'b0;
      end
   end

   assign gate_o = gate_q & ~ilim_i;

endmodule

// File: rtl/pcm_fb_select.sv
module pcm_fb_select
   import pcm_gate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_i,
   output logic [1:0] chan_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_o <= FB_CH2;
      else        chan_o <= sel_i ? FB_CH2 : FB_CH1;
   end

endmodule

// File: rtl/pcm_gate_ctrl.sv
module pcm_gate_ctrl
   import pcm_gate_pkg::*;
#(
   parameter int RAMP_W    = 8,
   parameter int TOP       = 40,
   parameter int BOT       = 0,
   parameter int UP        = 1,
   parameter int DN        = 8,
   parameter int SD_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic              ovp_i,
   input  logic              fb_sel_i,
   input  logic              trip_i,
   input  logic              ilim_i,
   output logic              gate_o,
   output logic              charge_o,
   output logic [RAMP_W-1:0] ramp_o,
   output logic [1:0]        fb_chan_o
);

   localparam int unsigned SPAN       = TOP - BOT;
   localparam int unsigned CLIMB_CYC  = ceil_steps(SPAN, UP);
   localparam int unsigned FALL_CYC   = ceil_steps(SPAN, DN);

   generate
      if (RAMP_W < 2 || RAMP_W > 24) begin : g_bad_w
         $error("pcm_gate_ctrl: RAMP_W out of range");
      end
      if (TOP >= (1 << RAMP_W) || BOT < 0 || BOT >= TOP) begin : g_bad_lim
         $error("pcm_gate_ctrl: ramp limits invalid");
      end
      if (UP < 1 || DN < 1 || BOT + DN >= (1 << (RAMP_W + 1))) begin : g_bad_step
         $error("pcm_gate_ctrl: ramp steps invalid");
      end
      if (CLIMB_CYC <= FALL_CYC) begin : g_bad_duty
         $error("pcm_gate_ctrl: climb must outlast fall");
      end
      if (SD_STAGES < 1 || SD_STAGES > 3) begin : g_bad_sync
         $error("pcm_gate_ctrl: SD_STAGES must be 1..3");
      end
   endgenerate

   ramp_phase_e phase;
   logic        start, stop, sd;

   pcm_ramp_osc #(
      .RAMP_W (RAMP_W),
      .TOP    (TOP),
      .BOT    (BOT),
      .UP     (UP),
      .DN     (DN)
   ) u_osc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ramp_o  (ramp_o),
      .phase_o (phase),
      .start_o (start),
      .end_o   (stop)
   );

   pcm_sd_sync #(
      .STAGES (SD_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt_i (halt_i),
      .ovp_i  (ovp_i),
      .sd_o   (sd)
   );

   pcm_gate_latch u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .end_i   (stop),
      .trip_i  (trip_i),
      .ilim_i  (ilim_i),
      .sd_i    (sd),
      .gate_o  (gate_o)
   );

   pcm_fb_select u_fb (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (fb_sel_i),
      .chan_o (fb_chan_o)
   );

   assign charge_o = (phase == PH_CLIMB);

endmodule

// File: rtl/pcm_gate_ctrl_chk.sv
module pcm_gate_ctrl_chk #(
   parameter int RAMP_W    = 8,
   parameter int TOP       = 40,
   parameter int BOT       = 0,
   parameter int UP        = 1,
   parameter int DN        = 8,
   parameter int SD_STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt_i,
   input logic              ovp_i,
   input logic              fb_sel_i,
   input logic              trip_i,
   input logic              ilim_i,
   input logic              gate_o,
   input logic              charge_o,
   input logic [RAMP_W-1:0] ramp_o,
   input logic [1:0]        fb_chan_o
);

   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   p_rise_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> $rose(charge_o));

   p_trip_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && trip_i) |=> !gate_o);

   p_fall_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !charge_o |-> !gate_o);

   p_halt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |-> ##(SD_STAGES + 1) !gate_o);

   p_ovp_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_i |-> ##(SD_STAGES + 1) !gate_o);

   p_no_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (charge_o && !gate_o) |=> (!gate_o || $rose(charge_o)));

   p_ilim_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ilim_i |-> !gate_o);

   p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(charge_o) && $past(trip_i)) |-> !gate_o);

   p_sel_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (fb_chan_o == ($past(fb_sel_i) ? 2'b10 : 2'b01)));

   p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(fb_chan_o));

   p_ramp_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ramp_o) >= BOT) && (int'(ramp_o) <= TOP));

   p_ramp_climb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && charge_o && $past(charge_o)) |-> (int'(ramp_o) == int'($past(ramp_o)) + UP));

endmodule

bind pcm_gate_ctrl pcm_gate_ctrl_chk #(
   .RAMP_W    (RAMP_W),
   .TOP       (TOP),
   .BOT       (BOT),
   .UP        (UP),
   .DN        (DN),
   .SD_STAGES (SD_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .halt_i    (halt_i),
   .ovp_i     (ovp_i),
   .fb_sel_i  (fb_sel_i),
   .trip_i    (trip_i),
   .ilim_i    (ilim_i),
   .gate_o    (gate_o),
   .charge_o  (charge_o),
   .ramp_o    (ramp_o),
   .fb_chan_o (fb_chan_o)
);

// File: tb/pcm_gate_ctrl_tb.sv
`timescale 1ns/1ps
module pcm_gate_ctrl_tb;

   localparam int CLIMB  = 40;
   localparam int PERIOD = 45;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt_i = 1'b0, ovp_i = 1'b0, fb_sel_i = 1'b1, trip_i = 1'b0, ilim_i = 1'b0;
   logic       gate_o, charge_o;
   logic [7:0] ramp_o;
   logic [1:0] fb_chan_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit         g;
      bit         chg;
      logic [1:0] fb;
      int         ramp;
      string      tag;
   } exp_t;

   exp_t  sb_q[$];
   string tag = "R10";
   int    n = 0;
   bit    g_m = 1'b0;
   bit    sd_m = 1'b0;

   always #2.5 clk = ~clk;

   pcm_gate_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_i    (halt_i),
      .ovp_i     (ovp_i),
      .fb_sel_i  (fb_sel_i),
      .trip_i    (trip_i),
      .ilim_i    (ilim_i),
      .gate_o    (gate_o),
      .charge_o  (charge_o),
      .ramp_o    (ramp_o),
      .fb_chan_o (fb_chan_o)
   );

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, expv);
      end
   endtask

   // Expected-item producer: built from the requirement text, using input values only
   always @(posedge clk) begin
      if (!rst_n) begin
         n = 0; g_m = 1'b0; sd_m = 1'b0;
      end else begin
         exp_t it;
         int   ph;
         bit   start, chg;
         n++;
         ph    = (n - 1) % PERIOD;
         start = (ph == 0);
         chg   = (ph < CLIMB);
         if (sd_m)                           g_m = 1'b0;
         else if (start)                     g_m = !trip_i && !ilim_i;
         else if (!chg || trip_i || ilim_i)  g_m = 1'b0;
         sd_m    = halt_i | ovp_i;
         it.g    = g_m;
         it.chg  = chg;
         it.fb   = fb_sel_i ? 2'b10 : 2'b01;
         it.ramp = chg ? ph : CLIMB - 8 * (ph - CLIMB);
         it.tag  = tag;
         sb_q.push_back(it);
      end
   end

   // Monitor: pops and compares away from the active edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         check(it.tag, int'(gate_o), int'(it.g && !ilim_i));
         check("R3", int'(charge_o), int'(it.chg));
         check("R9", int'(fb_chan_o), int'(it.fb));
         check("R10", int'(ramp_o), it.ramp);
      end
   end

   task automatic at_phase(input int p);
      do begin
         @(posedge clk); #1;
      end while (((n - 1) % PERIOD) != p);
   endtask

   task automatic cycles(input int k);
      for (int i = 0; i < k; i++) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", int'(gate_o), 0);
      check("R10", int'(charge_o), 0);
      check("R10", int'(ramp_o), 0);
      check("R9", int'(fb_chan_o), 2);
      @(posedge clk); #1;
      rst_n = 1'b1;

      tag = "R1";  cycles(PERIOD);
      tag = "R3";
      begin
         int on_cnt = 0;
         at_phase(PERIOD - 1);
         for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (gate_o) on_cnt++;
         end
         check("R3", on_cnt, CLIMB);
      end

      tag = "R2";  at_phase(10); trip_i = 1'b1; cycles(1); trip_i = 1'b0;
      at_phase(3);

      tag = "R8";  at_phase(42); trip_i = 1'b1; at_phase(5); trip_i = 1'b0;
      at_phase(3);

      tag = "R7";  at_phase(15); ilim_i = 1'b1; cycles(1); ilim_i = 1'b0;
      at_phase(3);

      tag = "R4";  at_phase(12); halt_i = 1'b1; cycles(6); halt_i = 1'b0;
      tag = "R6";  at_phase(3);

      tag = "R5";  at_phase(20); ovp_i = 1'b1; cycles(2); ovp_i = 1'b0;
      at_phase(43); ovp_i = 1'b1; at_phase(2); ovp_i = 1'b0;
      tag = "R6";  at_phase(6);

      tag = "R9";  at_phase(20); fb_sel_i = 1'b0; cycles(4); fb_sel_i = 1'b1; cycles(3);
      fb_sel_i = 1'b0; cycles(1); fb_sel_i = 1'b1;

      tag = "R1";  at_phase(44); trip_i = 1'b1; ilim_i = 1'b0; cycles(1); trip_i = 1'b0;
      cycles(PERIOD + 2);

      @(negedge clk); @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule